// File: doc/BRIEF.md
# Two-Stage Tick Clock Divider

This block derives a slower tick from one of four source ticks inside a single fabric clock domain. Each source arrives as a one-cycle clock-enable pulse. A 32-bit control word picks the source, a power-of-two prescale shift and an integer post-divide count. The block then emits one output tick per (2^shift × (count+1)) selected source ticks, plus a level that flips on every output tick and so gives a square wave at half the tick rate.

Software or a sequencer writes the control word through a plain write-enable port and can read it back at any time. The block restarts its counters cleanly whenever a write changes the configuration, so the first tick under a new setting comes after exactly one full period of the new ratio. A write that leaves the fields unchanged does not disturb the running count.

Top module: `tick_clock_divider`

## Requirements
- R1: Control bits 17:16 select which bit of `src_tick_i` feeds the divider (value k selects `src_tick_i[k]`); ticks on the other sources have no effect.
- R2: Control bits 5:4 hold a shift S; the prescale stage passes one tick per 2^S selected source ticks (ratio 1, 2, 4 or 8).
- R3: Control bits 12:8 hold a count D; the second stage passes one tick per D+1 prescaled ticks, so the total ratio is 2^S × (D+1), from 1 to 256.
- R4: `rd_data_o` returns the stored fields at bits 17:16, 12:8 and 5:4, one cycle after the write; every other bit reads as zero, and write data in those bits (bit 18 included) is dropped.
- R5: A write whose masked value differs from the stored word clears both counters; `tick_o` is low in the cycle after that write, selected ticks in the write cycle are discarded, and the next `tick_o` follows the 2^S × (D+1)-th selected tick after it.
- R6: A write whose masked value equals the stored word leaves the counters running, so the tick spacing is unchanged across it.
- R7: With S=0 and D=0, every selected source tick produces an output tick.
- R8: While `rst_ni` is low the control word is zero (source 0, ratio 1), and `tick_o` and `toggle_o` are low.
- R9: `toggle_o` inverts in exactly the cycles in which `tick_o` is high and holds otherwise.
- R10: `tick_o` is high for one cycle, the cycle after the clock edge that samples the selected source tick completing the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_tick_i | input | 4 | Source clock-enable ticks, one per source |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Stored control word, reserved bits zero |
| tick_o | output | 1 | Divided output tick |
| toggle_o | output | 1 | Level that flips on every output tick |

## Verification
A write lands at the next clock edge, so the read-back value and the counter restart are both visible one cycle after the write strobe; the output tick is registered, so it appears one cycle after the edge that samples the completing source tick. The bench drives inputs on the falling edge, checks the outputs at the following falling edge against a cycle-accurate count it keeps of selected source ticks since the last restarting write, and checks the read-back one nanosecond after the rising edge that stores it. Every shift and count pair is swept on source 0, and a subset of ratios is repeated on the slower sources 1 to 3.

// File: rtl/tick_div_pkg.sv
package tick_div_pkg;
  // Field positions are part of the register contract.
  localparam int SEL_W     = 2;
  localparam int SHIFT_W   = 2;
  localparam int DIV_W     = 5;
  localparam int SEL_LSB   = 16;
  localparam int SHIFT_LSB = 4;
  localparam int DIV_LSB   = 8;
  localparam int WORD_W    = 32;
  localparam int NUM_SRC   = 1 << SEL_W;

  typedef struct packed {
    logic [SEL_W-1:0]   sel;
    logic [SHIFT_W-1:0] shift;
    logic [DIV_W-1:0]   div;
  } cfg_t;

  function automatic cfg_t unpack_cfg(logic [WORD_W-1:0] w);
    cfg_t c;
    c.sel   = w[SEL_LSB   +: SEL_W];
    c.shift = w[SHIFT_LSB +: SHIFT_W];
    c.div   = w[DIV_LSB   +: DIV_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] pack_cfg(cfg_t c);
    logic [WORD_W-1:0] w;
    w = '0;
    w[SEL_LSB   +: SEL_W]   = c.sel;
    w[SHIFT_LSB +: SHIFT_W] = c.shift;
    w[DIV_LSB   +: DIV_W]   = c.div;
    return w;
  endfunction
endpackage

// File: rtl/tick_div_cfg_reg.sv
module tick_div_cfg_reg
  import tick_div_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output cfg_t              cfg_o,
  output logic              restart_o
);
  cfg_t cfg_q, wr_cfg;

  assign wr_cfg    = unpack_cfg(wr_data_i);
  assign restart_o = wr_en_i && (wr_cfg != cfg_q);
  assign cfg_o     = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_cfg;
  end
endmodule

// File: rtl/tick_div_prescale.sv
module tick_div_prescale #(
  parameter int SHIFT_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic               tick_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int CW = (1 << SHIFT_W) - 1;

  logic [CW-1:0] cnt_q, lim;
  logic          wrap;

  // lim = 2^shift - 1 as a thermometer code
  always_comb begin
    for (int i = 0; i < CW; i++) lim[i] = (i < int'(shift_i));
  end

  assign wrap   = (cnt_q == lim);
  assign tick_o = tick_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tick_div_count.sv
module tick_div_count #(
  parameter int DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o,
  output logic             toggle_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit, tick_q, tog_q;

  assign hit = tick_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      tog_q  <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= hit;
      if (hit)         tog_q <= ~tog_q;
      if (tick_i)      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o   = tick_q;
  assign toggle_o = tog_q;
endmodule

// File: rtl/tick_clock_divider.sv
module tick_clock_divider
  import tick_div_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_tick_i,
  input  logic               wr_en_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  output logic [WORD_W-1:0]  rd_data_o,
  output logic               tick_o,
  output logic               toggle_o
);
  cfg_t cfg;
  logic restart, sel_tick, pre_tick;

  tick_div_cfg_reg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .restart_o (restart)
  );

  assign sel_tick  = src_tick_i[cfg.sel];
  assign rd_data_o = pack_cfg(cfg);

  tick_div_prescale #(.SHIFT_W(SHIFT_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (sel_tick),
    .shift_i   (cfg.shift),
    .tick_o    (pre_tick)
  );

  tick_div_count #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (pre_tick),
    .div_i     (cfg.div),
    .tick_o    (tick_o),
    .toggle_o  (toggle_o)
  );
endmodule

// File: rtl/tick_clock_divider_chk.sv
module tick_clock_divider_chk
  import tick_div_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] src_tick_i,
  input logic               wr_en_i,
  input logic [WORD_W-1:0]  wr_data_i,
  input logic [WORD_W-1:0]  rd_data_o,
  input logic               tick_o,
  input logic               toggle_o
);
  localparam logic [WORD_W-1:0] RMASK =
    WORD_W'(((1 << SEL_W) - 1) << SEL_LSB) |
    WORD_W'(((1 << SHIFT_W) - 1) << SHIFT_LSB) |
    WORD_W'(((1 << DIV_W) - 1) << DIV_LSB);

  logic [SEL_W-1:0]   f_sel;
  logic [SHIFT_W-1:0] f_shift;
  logic [DIV_W-1:0]   f_div;
  assign f_sel   = rd_data_o[SEL_LSB +: SEL_W];
  assign f_shift = rd_data_o[SHIFT_LSB +: SHIFT_W];
  assign f_div   = rd_data_o[DIV_LSB +: DIV_W];

  assert_reserved_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~RMASK) == '0);

  assert_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i & RMASK));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  assert_restart_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ((wr_data_i & RMASK) != rd_data_o)) |=> !tick_o);

  assert_unity_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && f_shift == '0 && f_div == '0 && src_tick_i[f_sel]) |=> tick_o);

  assert_toggle_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> toggle_o != $past(toggle_o));

  assert_toggle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |-> $stable(toggle_o));
endmodule

bind tick_clock_divider tick_clock_divider_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_tick_i (src_tick_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .tick_o     (tick_o),
  .toggle_o   (toggle_o)
);

// File: tb/tick_clock_divider_bench.sv
module tick_clock_divider_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [3:0]  src_tick_i;
  logic        wr_en_i;
  logic [31:0] wr_data_i;
  logic [31:0] rd_data_o;
  logic        tick_o, toggle_o;

  localparam logic [31:0] FMASK = 32'h0003_1F30;

  int          checks = 0, errors = 0, cyc = 0, cnt = 0;
  logic [31:0] shadow = '0;
  logic        exp_tick = 1'b0, prev_tog = 1'b0;
  bit          done = 0;

  always #10 clk_i = ~clk_i;

  tick_clock_divider u_tick_clock_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_tick_i(src_tick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_data_o(rd_data_o),
    .tick_o(tick_o), .toggle_o(toggle_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int sel, int s, int d);
    return (32'(sel) << 16) | (32'(d) << 8) | (32'(s) << 4);
  endfunction

  // One cycle: check previous cycle's result, then drive and predict.
  task automatic step(input logic [3:0] src, input logic we, input logic [31:0] wd, input string tag);
    int ratio;
    @(negedge clk_i);
    chk(tick_o === exp_tick, {tag, " R10 tick_o"}, tick_o, exp_tick);
    chk(toggle_o === (prev_tog ^ exp_tick), "R9 toggle_o", toggle_o, prev_tog ^ exp_tick);
    prev_tog   = toggle_o;
    src_tick_i = src;
    wr_en_i    = we;
    wr_data_i  = wd;
    exp_tick   = 1'b0;
    if (we) begin
      if ((wd & FMASK) != shadow) begin
        shadow = wd & FMASK;
        cnt    = 0;
      end
    end else begin
      ratio = (1 << shadow[5:4]) * (int'(shadow[12:8]) + 1);
      if (src[shadow[17:16]]) begin
        cnt++;
        if (cnt == ratio) begin
          exp_tick = 1'b1;
          cnt      = 0;
        end
      end
    end
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic [3:0] src;
      for (int k = 0; k < 4; k++) src[k] = ((cyc % (k + 1)) == 0);
      step(src, 1'b0, '0, tag);
      cyc++;
    end
  endtask

  task automatic wr(input logic [31:0] d, input string tag);
    step(4'b0, 1'b1, d, tag);
    @(posedge clk_i); #1;
    chk(rd_data_o === (d & FMASK), {tag, " R4 readback"}, rd_data_o, d & FMASK);
  endtask

  initial begin
    rst_ni = 1'b0; src_tick_i = '0; wr_en_i = 1'b0; wr_data_i = '0;
    repeat (3) @(negedge clk_i);
    chk(rd_data_o === 32'h0, "R8 reset word", rd_data_o, 0);
    chk(tick_o === 1'b0, "R8 reset tick", tick_o, 0);
    chk(toggle_o === 1'b0, "R8 reset toggle", toggle_o, 0);
    rst_ni = 1'b1;
    run(8, "R7 R8");

    // reserved bits and out-of-field source index are dropped
    wr(32'h8004_0000, "R4");
    run(4, "R4 R7");

    // full shift x count sweep on source 0
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 32; d++) begin
        wr(word(0, s, d), "R2 R3");
        run(2 * (1 << s) * (d + 1) + 1, "R2 R3");
      end

    // slower sources
    for (int k = 1; k < 4; k++) begin
      wr(word(k, 0, 0), "R1 R7"); run(4 * (k + 1), "R1 R7");
      wr(word(k, 1, 2), "R1");    run(13 * (k + 1), "R1");
      wr(word(k, 2, 5), "R1");    run(49 * (k + 1), "R1");
      wr(word(k, 3, 31), "R1");   run(300 * (k + 1), "R1");
    end

    // restart mid-count
    wr(word(0, 1, 2), "R5"); run(4, "R5");
    wr(word(0, 1, 0), "R5"); run(9, "R5");
    wr(word(0, 0, 4), "R5"); run(3, "R5");
    wr(word(0, 0, 6), "R5"); run(16, "R5");

    // same-value write keeps counting
    wr(word(0, 1, 2), "R6"); run(4, "R6");
    wr(word(0, 1, 2) | 32'h8000_0001, "R6"); run(14, "R6");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20ns * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule